// File: doc/BRIEF.md
# Six-Channel DMA Grant Arbiter with Selectable Priority Mode

This block decides which of six DMA channels owns the transfer engine next. Every channel raises a request line. While the arbiter holds no grant and the controller is allowed to run, it registers one winner. It then holds that grant until the engine reports the transfer complete. Which channel wins depends on a 2-bit mode field in a global control word. Three modes are fixed orderings. The fourth mode is two-tier: channels 0..2 form a high group and channels 3..5 form a low group, and the winner rotates round robin inside each group.

The grant side acts as a one-deep stream. `gnt_valid` is the valid signal and `xfer_done` is the ready signal. A grant is offered and stays on `gnt`/`gnt_idx` unchanged for as many cycles as the engine stalls. It is consumed only in a cycle where `gnt_valid` and `xfer_done` are both high. `xfer_done` has no effect while no grant is held. The cycle after a grant is consumed is always idle, and the next decision is made at the edge after that.

Software controls the block through a write port for the control word. The word carries the enable bit, the halt and address-error flags, and the mode. A write takes effect at the clock edge on which it is sampled.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset no grant is held, the mode is 0 and enable is 0. The rotation pointers of the two-tier mode start at channel 0 for the high group and channel 3 for the low group.
- R2: In mode 0 the highest-priority requesting channel wins, in the order 0, 1, 2, 3, 4, 5 (highest first).
- R3: In mode 1 the order is 0, 2, 3, 1, 4, 5.
- R4: In mode 2 the order is 2, 0, 1, 3, 4, 5.
- R5: In mode 3, if any of channels 0..2 is requesting, the grant goes to one of them, whatever channels 3..5 request.
- R6: In mode 3 each group searches upward, wrapping, starting at its pointer. When a grant issued in mode 3 completes, the pointer of the group that was granted moves to the channel after the granted one, wrapping inside the group. The other group's pointer is unchanged.
- R7: No new grant is issued while enable is 0, halt is 1, or address-error is 1.
- R8: A grant is held with `gnt_idx` stable until `xfer_done` is seen. While it is held, `gnt` is one-hot with bit `gnt_idx` set; otherwise `gnt` is 0.
- R9: Writing the mode changes neither a grant in progress nor either rotation pointer. Grants issued in modes 0..2 do not move the pointers.
- R10: In the control word, bit 0 is enable, bit 2 is address-error, bit 3 is halt, and bits 9:8 are the mode. The word is written when `cfg_we` is 1.
- R11: A grant is issued only to a channel whose request was high in the cycle before the grant appears. A grant appears one cycle after the arbiter sees a request with no grant held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| req | input | 6 | Per-channel request lines |
| xfer_done | input | 1 | Transfer complete; consumes the held grant (ready) |
| gnt | output | 6 | One-hot grant |
| gnt_valid | output | 1 | A grant is held (valid) |
| gnt_idx | output | 3 | Index of the granted channel |

## Verification
The completion of a grant can fall in the same cycle as a control-word write. Two cases matter: the write selects a new mode, or the write sets halt. The bench provokes both by raising `xfer_done` and `cfg_we` in the same cycle while further requests stay pending. In the first case it checks that the next grant follows the newly written order. In the second case it checks that no grant follows. A third test changes requests and mode while a grant is stalled. It judges that the grant stays put and that the round-robin pointers continue from where the model expects them.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;
  localparam int NCH   = 6;
  localparam int GSZ   = 3;
  localparam int NGRP  = NCH / GSZ;
  localparam int IDX_W = $clog2(NCH);
  localparam int PTR_W = $clog2(GSZ);

  typedef enum logic [1:0] {
    MODE_LINEAR   = 2'd0,
    MODE_SWAP_B   = 2'd1,
    MODE_LEAD_TWO = 2'd2,
    MODE_TWO_TIER = 2'd3
  } prio_mode_e;

  typedef struct packed {
    logic       en;
    logic       aerr;
    logic       halt;
    prio_mode_e mode;
  } arb_ctrl_t;

  // channel that sits at a given rank (0 = highest) for a fixed mode
  function automatic logic [IDX_W-1:0] rank_chan(prio_mode_e m, int r);
    logic [IDX_W-1:0] c;
    c = IDX_W'(r);
    if (m == MODE_SWAP_B) begin
      case (r)
        1: c = IDX_W'(2);
        2: c = IDX_W'(3);
        3: c = IDX_W'(1);
        default: c = IDX_W'(r);
      endcase
    end else if (m == MODE_LEAD_TWO) begin
      case (r)
        0: c = IDX_W'(2);
        1: c = IDX_W'(0);
        2: c = IDX_W'(1);
        default: c = IDX_W'(r);
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/dmaarb_ctrl.sv
module dmaarb_ctrl
  import dmaarb_pkg::*;
#(
  parameter int CTRL_W   = 32,
  parameter int EN_BIT   = 0,
  parameter int AERR_BIT = 2,
  parameter int HALT_BIT = 3,
  parameter int MODE_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output arb_ctrl_t         ctrl,
  output logic              allow
);
  localparam int MODE_MSB = MODE_LSB + 1;

  logic unused_wbits;
  assign unused_wbits = ^{wdata[CTRL_W-1:MODE_MSB+1], wdata[MODE_LSB-1:HALT_BIT+1],
                          wdata[AERR_BIT-1:EN_BIT+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '{en: 1'b0, aerr: 1'b0, halt: 1'b0, mode: MODE_LINEAR};
    end else if (we) begin
      ctrl.en   <= wdata[EN_BIT];
      ctrl.aerr <= wdata[AERR_BIT];
      ctrl.halt <= wdata[HALT_BIT];
      ctrl.mode <= prio_mode_e'(wdata[MODE_MSB:MODE_LSB]);
    end
  end

  assign allow = ctrl.en & ~ctrl.halt & ~ctrl.aerr;

  // R10: a write lands its enable bit one cycle later
  p_en_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ctrl.en == $past(wdata[EN_BIT]));
  // R10: without a write the word is stable
  p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ctrl));
endmodule

// File: rtl/dmaarb_fixed_pick.sv
module dmaarb_fixed_pick
  import dmaarb_pkg::*;
(
  input  prio_mode_e       mode,
  input  logic [NCH-1:0]   req,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  // scan from lowest rank up so the highest-ranked requester is kept last
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int r = NCH - 1; r >= 0; r--) begin
      if (req[rank_chan(mode, r)]) begin
        hit = 1'b1;
        idx = rank_chan(mode, r);
      end
    end
  end
endmodule

// File: rtl/dmaarb_rr_group.sv
module dmaarb_rr_group
  import dmaarb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GSZ-1:0]   req,
  input  logic             adv,
  input  logic [PTR_W-1:0] adv_local,
  output logic             hit,
  output logic [PTR_W-1:0] pick
);
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (int'(adv_local) == GSZ - 1) ? '0 : adv_local + PTR_W'(1);
    end
  end

  // search order ptr, ptr+1, ... wrapping; farthest first so nearest wins
  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int k = GSZ - 1; k >= 0; k--) begin
      int j;
      j = (int'(ptr) + k) % GSZ;
      if (req[j]) begin
        hit  = 1'b1;
        pick = PTR_W'(j);
      end
    end
  end

  // R6: pointer moves only on completion of a grant from this group
  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr));
  p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < GSZ);
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dmaarb_pkg::*;
#(
  parameter int CTRL_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic [NCH-1:0]    req,
  input  logic              xfer_done,
  output logic [NCH-1:0]    gnt,
  output logic              gnt_valid,
  output logic [IDX_W-1:0]  gnt_idx
);
  arb_ctrl_t ctrl;
  logic      allow;

  dmaarb_ctrl #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .ctrl(ctrl), .allow(allow)
  );

  logic             fix_hit;
  logic [IDX_W-1:0] fix_idx;

  dmaarb_fixed_pick u_fixed (
    .mode(ctrl.mode), .req(req), .hit(fix_hit), .idx(fix_idx)
  );

  logic                   gnt_rr;
  logic                   consume;
  logic [NGRP-1:0]        g_hit;
  logic [NGRP-1:0]        g_adv;
  logic [PTR_W-1:0]       g_pick [NGRP];
  logic [PTR_W-1:0]       done_local;
  int                     done_grp;

  assign consume    = gnt_valid & xfer_done;
  assign done_grp   = int'(gnt_idx) / GSZ;
  assign done_local = PTR_W'(int'(gnt_idx) % GSZ);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign g_adv[g] = consume & gnt_rr & (done_grp == g);
    dmaarb_rr_group u_rr (
      .clk(clk), .rst_n(rst_n),
      .req(req[g*GSZ +: GSZ]),
      .adv(g_adv[g]), .adv_local(done_local),
      .hit(g_hit[g]), .pick(g_pick[g])
    );
  end

  // lower-numbered group always wins
  logic             rr_hit;
  logic [IDX_W-1:0] rr_idx;
  always_comb begin
    rr_hit = 1'b0;
    rr_idx = '0;
    for (int g = NGRP - 1; g >= 0; g--) begin
      if (g_hit[g]) begin
        rr_hit = 1'b1;
        rr_idx = IDX_W'(g * GSZ + int'(g_pick[g]));
      end
    end
  end

  logic             is_tier;
  logic             cand_hit;
  logic [IDX_W-1:0] cand_idx;
  logic             issue;

  assign is_tier  = (ctrl.mode == MODE_TWO_TIER);
  assign cand_hit = is_tier ? rr_hit : fix_hit;
  assign cand_idx = is_tier ? rr_idx : fix_idx;
  assign issue    = ~gnt_valid & allow & cand_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_idx   <= '0;
      gnt_rr    <= 1'b0;
    end else if (issue) begin
      gnt_valid <= 1'b1;
      gnt_idx   <= cand_idx;
      gnt_rr    <= is_tier;
    end else if (consume) begin
      gnt_valid <= 1'b0;
    end
  end

  always_comb begin
    gnt = '0;
    if (gnt_valid) gnt[gnt_idx] = 1'b1;
  end

  // R8: one-hot grant while held, nothing otherwise
  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> $countones(gnt) == 1 && gnt[gnt_idx]);
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid |-> gnt == '0);
  // R8: held until done
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && !xfer_done |=> gnt_valid && $stable(gnt_idx));
  // R7: no grant appears while gated
  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid && !allow |=> !gnt_valid);
  // R11: a fresh grant goes to a channel that was requesting
  p_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> ($past(req) & gnt) != '0);
  // R5: high group wins in two-tier mode
  p_tier_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue && is_tier && (req[GSZ-1:0] != '0) |=> int'(gnt_idx) < GSZ);
endmodule

// File: tb/tb_dma_prio_arbiter.sv
module tb_dma_prio_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [5:0]  req = '0;
  logic        xfer_done = 1'b0;
  logic [5:0]  gnt;
  logic        gnt_valid;
  logic [2:0]  gnt_idx;

  int checks = 0;
  int errors = 0;
  int ptr0 = 0;
  int ptr1 = 3;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_prio_arbiter dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req(req), .xfer_done(xfer_done), .gnt(gnt), .gnt_valid(gnt_valid),
    .gnt_idx(gnt_idx)
  );

  function automatic int ord(int m, int r);
    int t0 [6] = '{0, 1, 2, 3, 4, 5};
    int t1 [6] = '{0, 2, 3, 1, 4, 5};
    int t2 [6] = '{2, 0, 1, 3, 4, 5};
    if (m == 1) return t1[r];
    if (m == 2) return t2[r];
    return t0[r];
  endfunction

  function automatic int exp_fixed(int m, logic [5:0] r);
    for (int k = 0; k < 6; k++) if (r[ord(m, k)]) return ord(m, k);
    return -1;
  endfunction

  function automatic int exp_rr(logic [5:0] r);
    for (int k = 0; k < 3; k++) if (r[(ptr0 + k) % 3]) return (ptr0 + k) % 3;
    for (int k = 0; k < 3; k++) if (r[3 + (ptr1 - 3 + k) % 3]) return 3 + (ptr1 - 3 + k) % 3;
    return -1;
  endfunction

  function automatic void model_adv(int c);
    if (c < 3) ptr0 = (c + 1) % 3;
    else       ptr1 = 3 + (c - 3 + 1) % 3;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, expv);
    end
  endtask

  task automatic wr_ctrl(input int mode, input bit en, input bit halt, input bit aerr);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = '0;
    cfg_wdata[9:8] = mode[1:0];
    cfg_wdata[0] = en;
    cfg_wdata[2] = aerr;
    cfg_wdata[3] = halt;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // request, expect grant one edge later, then complete it
  task automatic grant_once(input logic [5:0] r, input int expv, input string rq);
    @(negedge clk);
    req = r;
    @(negedge clk);
    chk(gnt_valid && int'(gnt_idx) == expv && gnt == (6'b1 << expv), rq, int'(gnt_idx), expv);
    xfer_done = 1'b1;
    req = '0;
    @(negedge clk);
    xfer_done = 1'b0;
    chk(!gnt_valid && gnt == '0, rq, int'(gnt_valid), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!gnt_valid && gnt == '0, "R1", int'(gnt_valid), 0);
    req = 6'h3F;
    repeat (3) @(negedge clk);
    chk(!gnt_valid, "R1", int'(gnt_valid), 0);
    req = '0;
    wr_ctrl(0, 1, 0, 0);
    grant_once(6'h3E, 1, "R1");
  endtask

  task automatic t_fixed(input int m, input string rq);
    logic [5:0] pats [6] = '{6'h3F, 6'h3E, 6'h3A, 6'h32, 6'h30, 6'h0B};
    wr_ctrl(m, 1, 0, 0);
    foreach (pats[i]) grant_once(pats[i], exp_fixed(m, pats[i]), rq);
  endtask

  task automatic t_two_tier;
    logic [5:0] pats [9] = '{6'h3F, 6'h3F, 6'h3F, 6'h38, 6'h38, 6'h3F, 6'h05, 6'h28, 6'h3F};
    wr_ctrl(3, 1, 0, 0);
    foreach (pats[i]) begin
      int e;
      e = exp_rr(pats[i]);
      grant_once(pats[i], e, (pats[i][2:0] != 0) ? "R5" : "R6");
      model_adv(e);
    end
  endtask

  task automatic t_gate;
    wr_ctrl(0, 0, 0, 0);
    req = 6'h3F;
    repeat (3) @(negedge clk);
    chk(!gnt_valid, "R7", int'(gnt_valid), 0);
    req = '0;
    wr_ctrl(0, 1, 1, 0);
    req = 6'h3F;
    repeat (3) @(negedge clk);
    chk(!gnt_valid, "R7", int'(gnt_valid), 0);
    req = '0;
    wr_ctrl(0, 1, 0, 1);
    req = 6'h3F;
    repeat (3) @(negedge clk);
    chk(!gnt_valid, "R7", int'(gnt_valid), 0);
    req = '0;
    cfg_we = 1'b1;
    cfg_wdata = 32'h0000_0001;
    req = 6'h10;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    chk(gnt_valid && gnt_idx == 3'd4, "R10", int'(gnt_idx), 4);
    xfer_done = 1'b1;
    req = '0;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic t_hold;
    int e;
    wr_ctrl(3, 1, 0, 0);
    @(negedge clk);
    req = 6'h30;
    e = exp_rr(6'h30);
    @(negedge clk);
    chk(gnt_valid && int'(gnt_idx) == e, "R11", int'(gnt_idx), e);
    req = 6'h01;
    cfg_we = 1'b1;
    cfg_wdata = 32'h0000_0001;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (4) @(negedge clk);
    chk(gnt_valid && int'(gnt_idx) == e, "R8", int'(gnt_idx), e);
    chk(gnt_valid && int'(gnt_idx) == e, "R9", int'(gnt_idx), e);
    xfer_done = 1'b1;
    req = '0;
    @(negedge clk);
    xfer_done = 1'b0;
    model_adv(e);
    grant_once(6'h07, 0, "R9");
    wr_ctrl(3, 1, 0, 0);
    e = exp_rr(6'h38);
    grant_once(6'h38, e, "R9");
    model_adv(e);
  endtask

  task automatic t_coincide;
    wr_ctrl(0, 1, 0, 0);
    @(negedge clk);
    req = 6'h0F;
    @(negedge clk);
    chk(gnt_valid && gnt_idx == 3'd0, "R2", int'(gnt_idx), 0);
    req = 6'h0E;
    xfer_done = 1'b1;
    cfg_we = 1'b1;
    cfg_wdata = 32'h0000_0201;
    @(negedge clk);
    xfer_done = 1'b0;
    cfg_we = 1'b0;
    chk(!gnt_valid, "R8", int'(gnt_valid), 0);
    @(negedge clk);
    chk(gnt_valid && gnt_idx == 3'd2, "R4", int'(gnt_idx), 2);
    req = 6'h0E;
    xfer_done = 1'b1;
    cfg_we = 1'b1;
    cfg_wdata = 32'h0000_0209;
    @(negedge clk);
    xfer_done = 1'b0;
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    chk(!gnt_valid, "R7", int'(gnt_valid), 0);
    req = '0;
    @(negedge clk);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    chk(!gnt_valid, "R8", int'(gnt_valid), 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fixed(0, "R2");
    t_fixed(1, "R3");
    t_fixed(2, "R4");
    t_two_tier();
    t_gate();
    t_hold();
    t_coincide();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule